// File: doc/BRIEF.md
# Two-Address Register ALU Datapath

This block is a single-cycle execution datapath for a small two-address machine. An instruction carries three fields: a source register index, a destination register index and an opcode. The destination register is both the first operand and the place the result is written. Both operands are read from an eight-entry register file and fed to every functional unit at once. The opcode then keeps one of the unit outputs, and that result is written back into the destination register on the next rising clock edge.

A parameter selects how the kept result is chosen. In the default form a result multiplexer picks the output of one unit. In the alternative form a decoder enables one unit, every disabled unit drives zeros, and the unit outputs are merged with a bitwise OR. Both forms leave the same contents in the register file.

A debug port reads any register combinationally. It can also write one register, so that a test or a loader can put operands in place. When a debug write and an instruction write target the same register in the same cycle, the instruction result is kept.

Top module: `two_addr_alu`

## Requirements
- R1: A synchronous reset clears all eight registers to zero, and they read back as zero once it is released.
- R2: While `ins_valid` is low and `dbg_we` is low, no register changes, whatever the instruction fields hold.
- R3: Opcode 0 (add) writes `(D + S) mod 256` into register `dst_idx`, where D is the old value of register `dst_idx` and S is the old value of register `src_idx`.
- R4: Opcode 1 (subtract) writes `(D - S) mod 256` into register `dst_idx`.
- R5: Opcodes 2, 3 and 4 write the bitwise AND, OR and XOR of D and S into register `dst_idx`.
- R6: Opcode 5 (move) writes S into register `dst_idx`.
- R7: Opcodes 6 and 7 write nothing, even with `ins_valid` high.
- R8: A valid instruction changes only register `dst_idx`. All other registers keep their values.
- R9: When `src_idx` equals `dst_idx`, both operands take the value from before the write. The new value is seen only after the clock edge that writes it.
- R10: `dbg_rdata` always shows the current contents of register `dbg_idx`, with no clock delay.
- R11: The OR-combine form (`OR_COMBINE=1`) gives register contents bit-identical to the multiplexer form for the same input sequence.
- R12: With `dbg_we` high, `dbg_wdata` is written into register `dbg_idx` on the clock edge. If a valid writing instruction targets the same register in that cycle, the instruction result wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | 1 | Instruction strobe; the instruction is executed while high |
| src_idx | input | 3 | Source register index |
| dst_idx | input | 3 | Destination register index (operand and write target) |
| opcode | input | 3 | Operation: 0 add, 1 subtract, 2 and, 3 or, 4 xor, 5 move, 6/7 no write |
| dbg_we | input | 1 | Debug write enable |
| dbg_idx | input | 3 | Debug register index, used for both read and write |
| dbg_wdata | input | 8 | Debug write data |
| dbg_rdata | output | 8 | Contents of register `dbg_idx` |

## Verification
Every instruction or debug write becomes visible one rising edge after the cycle in which it is presented, while the debug read path has no delay. The bench therefore drives a step on the falling edge, lets one rising edge pass and updates its behavioural model there. After the following falling edge it walks `dbg_idx` over all eight registers, settling for a short delay before each compare. Both parameter forms are instantiated side by side and compared with the same model on every step, so a mismatch between the two modes appears in the same cycle as a wrong result.

// File: rtl/two_addr_alu.sv
module two_addr_alu #(
  parameter int DATA_W     = 8,
  parameter int NREGS      = 8,
  parameter bit OR_COMBINE = 1'b0,
  localparam int IDX_W     = $clog2(NREGS),
  localparam int OP_W      = 3,
  localparam int NSEL      = 2 ** OP_W,
  localparam int NUNITS    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [OP_W-1:0]   opcode,
  input  logic              dbg_we,
  input  logic [IDX_W-1:0]  dbg_idx,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata
);

  logic [NREGS-1:0][DATA_W-1:0] rf;
  logic [NSEL-1:0][DATA_W-1:0]  unit_out;
  logic [DATA_W-1:0]            opd_d, opd_s, result;
  logic                         op_ok;

  assign opd_d = rf[dst_idx];
  assign opd_s = rf[src_idx];
  assign op_ok = opcode < OP_W'(NUNITS);

  assign unit_out[0] = opd_d + opd_s;
  assign unit_out[1] = opd_d - opd_s;
  assign unit_out[2] = opd_d & opd_s;
  assign unit_out[3] = opd_d | opd_s;
  assign unit_out[4] = opd_d ^ opd_s;
  assign unit_out[5] = opd_s;

  generate
    for (genvar u = NUNITS; u < NSEL; u++) begin : g_idle
      assign unit_out[u] = '0;
    end

    if (OR_COMBINE) begin : g_or
      logic [NSEL-1:0] unit_en;
      assign unit_en = op_ok ? (NSEL'(1) << opcode) : '0;
      always_comb begin
        result = '0;
        for (int u = 0; u < NSEL; u++)
          result = result | (unit_out[u] & {DATA_W{unit_en[u]}});
      end
    end else begin : g_mux
      assign result = unit_out[opcode];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rf <= '0;
    end else begin
      if (dbg_we)
        rf[dbg_idx] <= dbg_wdata;
      if (ins_valid && op_ok)
        rf[dst_idx] <= result;
    end
  end

  assign dbg_rdata = rf[dbg_idx];

endmodule

module two_addr_alu_chk #(
  parameter int DATA_W = 8,
  parameter int NREGS  = 8,
  localparam int IDX_W = $clog2(NREGS)
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         ins_valid,
  input logic [IDX_W-1:0]             src_idx,
  input logic [IDX_W-1:0]             dst_idx,
  input logic [2:0]                   opcode,
  input logic                         dbg_we,
  input logic [IDX_W-1:0]             dbg_idx,
  input logic [NREGS-1:0][DATA_W-1:0] rf
);

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> rf == '0);

  generate
    for (genvar i = 0; i < NREGS; i++) begin : g_hold
      // R2 and R8: untouched registers keep their value
      p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!(ins_valid && dst_idx == IDX_W'(i)) && !(dbg_we && dbg_idx == IDX_W'(i)))
        |=> $stable(rf[i]));
    end
  endgenerate

  p_add_r3: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && opcode == 3'd0) |=>
      rf[$past(dst_idx)] == DATA_W'($past(rf[dst_idx]) + $past(rf[src_idx])));

  p_sub_r4: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && opcode == 3'd1) |=>
      rf[$past(dst_idx)] == DATA_W'($past(rf[dst_idx]) - $past(rf[src_idx])));

  p_xor_r5: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && opcode == 3'd4) |=>
      rf[$past(dst_idx)] == ($past(rf[dst_idx]) ^ $past(rf[src_idx])));

  p_move_r6: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && opcode == 3'd5) |=> rf[$past(dst_idx)] == $past(rf[src_idx]));

  p_nowrite_r7: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && opcode >= 3'd6 && !dbg_we) |=> $stable(rf));

endmodule

bind two_addr_alu two_addr_alu_chk #(.DATA_W(DATA_W), .NREGS(NREGS)) chk_i (
  .clk(clk), .rst(rst), .ins_valid(ins_valid), .src_idx(src_idx),
  .dst_idx(dst_idx), .opcode(opcode), .dbg_we(dbg_we), .dbg_idx(dbg_idx), .rf(rf)
);

// File: tb/two_addr_alu_tb.sv
module two_addr_alu_tb_top;
  localparam int CLK_PERIOD = 20;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ins_valid = 1'b0;
  logic [2:0] src_idx = '0, dst_idx = '0, opcode = '0, dbg_idx = '0;
  logic       dbg_we = 1'b0;
  logic [7:0] dbg_wdata = '0;
  logic [7:0] rd_mux, rd_or;

  int checks = 0, errors = 0;
  int model [8];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  two_addr_alu #(.OR_COMBINE(1'b0)) dut_i (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .src_idx(src_idx),
    .dst_idx(dst_idx), .opcode(opcode), .dbg_we(dbg_we), .dbg_idx(dbg_idx),
    .dbg_wdata(dbg_wdata), .dbg_rdata(rd_mux));

  two_addr_alu #(.OR_COMBINE(1'b1)) dut_or_i (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .src_idx(src_idx),
    .dst_idx(dst_idx), .opcode(opcode), .dbg_we(dbg_we), .dbg_idx(dbg_idx),
    .dbg_wdata(dbg_wdata), .dbg_rdata(rd_or));

  task automatic check_all(string tag);
    for (int i = 0; i < 8; i++) begin
      dbg_idx = 3'(i);
      #1;
      checks++;
      if (rd_mux !== 8'(model[i])) begin
        errors++;
        $display("FAIL %s mux-mode r%0d actual %0h expected %0h", tag, i, rd_mux, model[i]);
      end
      checks++;
      if (rd_or !== 8'(model[i])) begin
        errors++;
        $display("FAIL %s or-mode (R11) r%0d actual %0h expected %0h", tag, i, rd_or, model[i]);
      end
    end
  endtask

  task automatic step(string tag, bit v, int s, int d, int op,
                      bit we = 0, int widx = 0, int wdat = 0);
    int dv, sv, res;
    ins_valid = v; src_idx = 3'(s); dst_idx = 3'(d); opcode = 3'(op);
    dbg_we = we; dbg_idx = 3'(widx); dbg_wdata = 8'(wdat);
    dv = model[d]; sv = model[s];
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 8; i++) model[i] = 0;
    end else begin
      if (we) model[widx] = wdat & 255;
      if (v && op < 6) begin
        case (op)
          0: res = dv + sv;
          1: res = dv - sv;
          2: res = dv & sv;
          3: res = dv | sv;
          4: res = dv ^ sv;
          default: res = sv;
        endcase
        model[d] = res & 255;
      end
    end
    @(negedge clk);
    ins_valid = 0; dbg_we = 0;
    check_all(tag);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 0;
    rst = 1;
    repeat (3) step("R1 reset", 1, 1, 2, 0, 1, 3, 8'h55);
    rst = 0;
    check_all("R1 after reset");

    for (int i = 0; i < 8; i++)
      step("R12 debug load", 0, 0, 0, 0, 1, i, 8'h11 * (i + 1) + 3);
    step("R10 debug read", 0, 0, 0, 0);

    step("R3 add", 1, 2, 1, 0);
    step("R3 add wrap", 1, 7, 6, 0);
    step("R4 sub", 1, 1, 4, 1);
    step("R4 sub borrow", 1, 7, 0, 1);
    step("R5 and", 1, 3, 5, 2);
    step("R5 or", 1, 0, 2, 3);
    step("R5 xor", 1, 6, 3, 4);
    step("R6 move", 1, 5, 7, 5);
    step("R7 op6", 1, 1, 2, 6);
    step("R7 op7", 1, 4, 5, 7);
    step("R2 no valid", 0, 3, 1, 0);
    step("R2 no valid sub", 0, 6, 6, 1);
    step("R9 add self", 1, 3, 3, 0);
    step("R9 xor self", 1, 2, 2, 4);
    step("R9 sub self", 1, 5, 5, 1);
    step("R8/R10 isolation", 1, 0, 6, 3);
    step("R12 conflict instr wins", 1, 1, 4, 0, 1, 4, 8'hA5);
    step("R12 op7 lets debug write", 1, 1, 4, 7, 1, 4, 8'h3C);
    step("R12 split targets", 1, 4, 2, 1, 1, 0, 8'hE7);

    for (int n = 0; n < 400; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step("R11 random", r < 85, int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
           int'($urandom_range(0, 7)), r > 90, int'($urandom_range(0, 7)),
           int'($urandom_range(0, 255)));
    end

    rst = 1;
    step("R1 mid reset", 1, 2, 3, 0);
    rst = 0;
    step("R1 held zero", 1, 2, 3, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule